// File: doc/BRIEF.md
# Ultra DMA Write-Burst Receiver

This block is the device-side receiver for the host-to-device data phase of a parallel ATA Ultra DMA write burst. Once the core asks for a burst, the block raises the DMA request. It waits for the host's active-low acknowledge. It then stores one 16-bit word from the data bus on every transition of the host strobe, rising or falling, into a small internal FIFO. A sector buffer on the core side drains that FIFO through a show-ahead pop port.

The host strobe and data bus enter asynchronously. They pass through the same synchroniser depth, and the data value registered beside the strobe transition is the one stored. The host may leave any gap between strobe transitions. The block paces the host with an active-low ready output that rises while the FIFO nears full. A host STOP ends the burst, drops the request and reports how many words were accepted. A word that arrives when the FIFO has no room is dropped and marked by a sticky flag.

Top module: `udma_wr_rx`

## Requirements
- R1: After reset, dma_req is 0, dev_ready_n is 1, rx_valid is 0, burst_done is 0, rx_overflow is 0 and rx_count is 0.
- R2: A burst_start pulse while idle raises dma_req on the next clock. dma_req stays high until the burst ends.
- R3: Strobe transitions that occur before the host drives host_ack_n low are not captured. rx_valid stays 0.
- R4: Every rising and every falling transition of host_strobe, seen while the burst is granted, stores exactly one word: the host_data value present with that transition. Words leave in arrival order.
- R5: Any idle time between strobe transitions, including many cycles, causes no loss or duplication of words.
- R6: dev_ready_n is 0 only while the burst is granted and the FIFO has more than PAUSE_FREE free entries. With DEPTH=8 and PAUSE_FREE=4, it is low with 3 words held and high with 4 held.
- R7: host_stop during a granted burst produces, on the next clock, a single-cycle burst_done with dma_req low and rx_count equal to the number of words accepted in that burst. Strobe transitions after that are ignored.
- R8: A strobe transition that arrives while the FIFO is full drops its word and sets rx_overflow. rx_overflow stays set until reset or the next accepted burst_start, which also clears rx_count.
- R9: rx_valid is high whenever the FIFO holds a word, and rx_data shows the oldest one. rx_pop removes it. A pop while empty has no effect on later data.
- R10: burst_start during an active burst is ignored. The burst continues and rx_count is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| burst_start | input | 1 | Core request to begin a write burst (pulse) |
| host_ack_n | input | 1 | DMA acknowledge from host, active low |
| host_stop | input | 1 | Host STOP, ends the burst |
| host_strobe | input | 1 | Host data strobe, both edges active |
| host_data | input | DW | Host data bus |
| dma_req | output | 1 | DMA request to host |
| dev_ready_n | output | 1 | Device ready for data, active low |
| rx_pop | input | 1 | Remove the oldest FIFO word |
| rx_valid | output | 1 | FIFO holds at least one word |
| rx_data | output | DW | Oldest FIFO word |
| burst_done | output | 1 | One-cycle end-of-burst pulse |
| rx_count | output | CNT_W | Words accepted in current or last burst |
| rx_overflow | output | 1 | Sticky drop-on-full flag |

## Verification
The properties assume that host_data is held steady across each strobe transition for the synchroniser depth. They also assume that transitions are spaced at least three core clocks apart, so one transition is fully counted before the next is seen. The stimulus drives data and strobe together on the falling clock edge. It waits at least three cycles between transitions and, outside the overflow case, sends only while dev_ready_n is low. STOP is driven only after the last transition has settled, so every word the bench sends is accounted for before the burst closes.

// File: rtl/udma_rx_pkg.sv
package udma_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2,
    ST_DONE = 2'd3
  } rx_state_e;

  // free slots left in a FIFO of the given depth
  function automatic int unsigned free_slots(input int unsigned depth,
                                             input int unsigned level);
    return (level >= depth) ? 0 : depth - level;
  endfunction

  // host may keep sending only while more than margin slots remain
  function automatic logic room_to_run(input int unsigned free,
                                       input int unsigned margin);
    return free > margin;
  endfunction

  // count increment that holds at its ceiling
  function automatic int unsigned sat_inc(input int unsigned val,
                                          input int unsigned maxv);
    return (val >= maxv) ? maxv : val + 1;
  endfunction

endpackage

// File: rtl/udma_strobe_sync.sv
module udma_strobe_sync #(
  parameter int DW     = 16,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe_in,
  input  logic [DW-1:0] data_in,
  output logic          edge_seen,
  output logic [DW-1:0] edge_data
);
  logic [STAGES:0] stb_q;
  logic [DW-1:0]   dat_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q[0] <= 1'b0;
      dat_q[0] <= '0;
    end else begin
      stb_q[0] <= strobe_in;
      dat_q[0] <= data_in;
    end
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stb
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_q[i] <= 1'b0;
      else        stb_q[i] <= stb_q[i-1];
    end
  end

  for (genvar j = 1; j < STAGES; j++) begin : g_dat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dat_q[j] <= '0;
      else        dat_q[j] <= dat_q[j-1];
    end
  end

  // a change between the last two strobe stages marks either edge
  assign edge_seen = stb_q[STAGES] ^ stb_q[STAGES-1];
  assign edge_data = dat_q[STAGES-1];
endmodule

// File: rtl/udma_rx_fifo.sv
module udma_rx_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output logic          full,
  output logic          empty,
  output logic [LW-1:0] level
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_pop;

  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign full   = (32'(level) == DEPTH);
  assign empty  = (level == '0);
  assign do_pop = pop && !empty;

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push && !full) wr_ptr <= ptr_step(wr_ptr);
      if (do_pop)        rd_ptr <= ptr_step(rd_ptr);
      case ({push && !full, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign head_data = mem[rd_ptr];
endmodule

// File: rtl/udma_rx_ctrl.sv
module udma_rx_ctrl
  import udma_rx_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int PAUSE_FREE = 4,
  parameter int CNT_W      = 16,
  localparam int LW        = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             ack_n,
  input  logic             stop,
  input  logic             edge_seen,
  input  logic             fifo_full,
  input  logic [LW-1:0]    fifo_level,
  output logic             push,
  output logic             start_accept,
  output logic             dma_req,
  output logic             ready_n,
  output logic             done,
  output logic [CNT_W-1:0] count,
  output logic             overflow
);
  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

  rx_state_e state, state_nx;
  logic      capture_en, drop;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: if (start)  state_nx = ST_REQ;
      ST_REQ:  if (!ack_n) state_nx = ST_XFER;
      ST_XFER: if (stop)   state_nx = ST_DONE;
      default:             state_nx = ST_IDLE;
    endcase
  end

  assign start_accept = (state == ST_IDLE) && start;
  assign capture_en   = (state == ST_XFER) && !ack_n && !stop;
  assign push         = capture_en && edge_seen && !fifo_full;
  assign drop         = capture_en && edge_seen && fifo_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      state <= state_nx;
      if (start_accept) begin
        count    <= '0;
        overflow <= 1'b0;
      end else begin
        if (push) count <= CNT_W'(sat_inc(32'(count), CNT_MAX));
        if (drop) overflow <= 1'b1;
      end
    end
  end

  assign dma_req = (state == ST_REQ) || (state == ST_XFER);
  assign done    = (state == ST_DONE);
  assign ready_n = !((state == ST_XFER) && !ack_n &&
                     room_to_run(free_slots(DEPTH, 32'(fifo_level)), PAUSE_FREE));
endmodule

// File: rtl/udma_wr_rx.sv
module udma_wr_rx #(
  parameter int DW          = 16,
  parameter int DEPTH       = 8,
  parameter int PAUSE_FREE  = 4,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             burst_start,
  input  logic             host_ack_n,
  input  logic             host_stop,
  input  logic             host_strobe,
  input  logic [DW-1:0]    host_data,
  output logic             dma_req,
  output logic             dev_ready_n,
  input  logic             rx_pop,
  output logic             rx_valid,
  output logic [DW-1:0]    rx_data,
  output logic             burst_done,
  output logic [CNT_W-1:0] rx_count,
  output logic             rx_overflow
);
  localparam int LW = $clog2(DEPTH + 1);

  logic          edge_seen;
  logic [DW-1:0] edge_data;
  logic          push_fire;
  logic          start_accept;
  logic          fifo_full, fifo_empty;
  logic [LW-1:0] fifo_level;

  udma_strobe_sync #(.DW(DW), .STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe_in (host_strobe),
    .data_in   (host_data),
    .edge_seen (edge_seen),
    .edge_data (edge_data)
  );

  udma_rx_ctrl #(.DEPTH(DEPTH), .PAUSE_FREE(PAUSE_FREE), .CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (burst_start),
    .ack_n        (host_ack_n),
    .stop         (host_stop),
    .edge_seen    (edge_seen),
    .fifo_full    (fifo_full),
    .fifo_level   (fifo_level),
    .push         (push_fire),
    .start_accept (start_accept),
    .dma_req      (dma_req),
    .ready_n      (dev_ready_n),
    .done         (burst_done),
    .count        (rx_count),
    .overflow     (rx_overflow)
  );

  udma_rx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_fire),
    .push_data (edge_data),
    .pop       (rx_pop),
    .head_data (rx_data),
    .full      (fifo_full),
    .empty     (fifo_empty),
    .level     (fifo_level)
  );

  assign rx_valid = !fifo_empty;
endmodule

// File: rtl/udma_wr_rx_chk.sv
module udma_wr_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic dma_req,
  input logic dev_ready_n,
  input logic burst_done,
  input logic rx_overflow,
  input logic rx_valid,
  input logic start_accept,
  input logic push_fire,
  input logic fifo_full
);
  // R2: request only rises after a start was taken
  p_req_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req) |-> $past(start_accept));

  // R6: ready is never offered outside a burst or with a full FIFO
  p_ready_in_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_ready_n |-> (dma_req && !fifo_full));

  // R7: end pulse lasts one cycle and comes with the request dropped
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !burst_done);
  p_done_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> !dma_req);

  // R8: overflow is sticky until a new start, and no push lands on full
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overflow && !start_accept) |=> rx_overflow);
  p_no_push_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |-> !fifo_full);

  // R9: data only appears after a push
  p_valid_from_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(push_fire));
endmodule

bind udma_wr_rx udma_wr_rx_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dma_req      (dma_req),
  .dev_ready_n  (dev_ready_n),
  .burst_done   (burst_done),
  .rx_overflow  (rx_overflow),
  .rx_valid     (rx_valid),
  .start_accept (start_accept),
  .push_fire    (push_fire),
  .fifo_full    (fifo_full)
);

// File: tb/udma_wr_rx_bench.sv
module udma_wr_rx_bench;
  localparam int DW = 16, DEPTH = 8, PAUSE_FREE = 4, CNT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic burst_start = 0, host_ack_n = 1, host_stop = 0, host_strobe = 0, rx_pop = 0;
  logic [DW-1:0] host_data = '0;
  logic dma_req, dev_ready_n, rx_valid, burst_done, rx_overflow;
  logic [DW-1:0] rx_data;
  logic [CNT_W-1:0] rx_count;

  always #5 clk = ~clk;

  udma_wr_rx #(.DW(DW), .DEPTH(DEPTH), .PAUSE_FREE(PAUSE_FREE), .CNT_W(CNT_W)) u_udma_wr_rx (
    .clk(clk), .rst_n(rst_n), .burst_start(burst_start), .host_ack_n(host_ack_n),
    .host_stop(host_stop), .host_strobe(host_strobe), .host_data(host_data),
    .dma_req(dma_req), .dev_ready_n(dev_ready_n), .rx_pop(rx_pop), .rx_valid(rx_valid),
    .rx_data(rx_data), .burst_done(burst_done), .rx_count(rx_count), .rx_overflow(rx_overflow));

  int n_chk = 0, n_fail = 0;
  bit pop_en = 0, pop_all = 0, finished = 0;
  int sent = 0;
  logic [DW-1:0] exp_q[$];

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // bench rule: ready offered while more than PAUSE_FREE slots are free
  function automatic bit exp_ready(input int held);
    return (DEPTH - held) > PAUSE_FREE;
  endfunction

  // one clock, ending at a falling edge; optionally pop and compare the head
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    rx_pop = 0;
    if (pop_en && rx_valid && (pop_all || ($urandom % 2 == 0))) begin
      if (exp_q.size() == 0) check(0, "R9 unexpected word", rx_data, 0);
      else begin
        check(rx_data == exp_q[0], "R4 word order/value", rx_data, exp_q[0]);
        void'(exp_q.pop_front());
      end
      rx_pop = 1;
    end
  endtask

  task automatic send(input logic [DW-1:0] w, input bit obey, input int gap);
    while (obey && dev_ready_n) step();
    host_data = w;
    host_strobe = ~host_strobe;
    if (pop_en || exp_q.size() < DEPTH) begin
      exp_q.push_back(w);
      sent++;
    end
    repeat (gap) step();
  endtask

  task automatic open_burst();
    burst_start = 1;
    step();
    burst_start = 0;
    check(dma_req == 1, "R2 request raised", dma_req, 1);
    check(rx_count == 0, "R8 count cleared at start", rx_count, 0);
    sent = 0;
    host_ack_n = 0;
    step();
    step();
  endtask

  task automatic close_burst();
    host_stop = 1;
    step();
    host_stop = 0;
    check(burst_done == 1, "R7 done pulse", burst_done, 1);
    check(dma_req == 0, "R7 request dropped", dma_req, 0);
    check(rx_count == CNT_W'(sent), "R7 word count", rx_count, sent);
    step();
    check(burst_done == 0, "R7 pulse one cycle", burst_done, 0);
    host_ack_n = 1;
  endtask

  task automatic drain();
    pop_en = 1;
    pop_all = 1;
    for (int k = 0; k < 200 && exp_q.size() > 0; k++) step();
    pop_all = 0;
    check(exp_q.size() == 0, "R9 all words delivered", exp_q.size(), 0);
    step();
    check(rx_valid == 0, "R9 FIFO empty after drain", rx_valid, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(dma_req == 0 && dev_ready_n == 1 && rx_valid == 0, "R1 reset outputs", {dma_req, dev_ready_n, rx_valid}, 3'b010);
    check(burst_done == 0 && rx_overflow == 0 && rx_count == 0, "R1 reset status", rx_count, 0);
    rst_n = 1;
    step();

    // R3: transitions before acknowledge are ignored
    burst_start = 1; step(); burst_start = 0;
    check(dma_req == 1, "R2 request raised", dma_req, 1);
    host_strobe = ~host_strobe; repeat (4) step();
    host_strobe = ~host_strobe; repeat (4) step();
    check(rx_valid == 0, "R3 no capture before ack", rx_valid, 0);
    check(dev_ready_n == 1, "R6 not ready before ack", dev_ready_n, 1);
    sent = 0;
    host_ack_n = 0; step(); step();

    // R6: pause threshold with no pops
    pop_en = 0;
    for (int i = 0; i < 3; i++) send(16'hA000 + 16'(i), 0, 3);
    check(dev_ready_n == !exp_ready(3), "R6 ready with 3 held", dev_ready_n, !exp_ready(3));
    send(16'hA003, 0, 3);
    check(dev_ready_n == !exp_ready(4), "R6 paused with 4 held", dev_ready_n, !exp_ready(4));
    pop_en = 1;
    // R10: start during burst ignored
    burst_start = 1; step(); burst_start = 0;
    check(dma_req == 1, "R10 burst continues", dma_req, 1);
    send(16'hA004, 1, 3);
    // R5: long pause
    repeat (300) step();
    send(16'hA005, 1, 5);
    close_burst();
    // R7: transitions after stop ignored
    host_strobe = ~host_strobe; repeat (4) step();
    drain();

    // R4/R5 random bursts
    for (int b = 0; b < 6; b++) begin
      open_burst();
      for (int i = 0, n = 5 + $urandom % 36; i < n; i++)
        send(16'($urandom), 1, 3 + $urandom % 6 + ((($urandom % 10) == 0) ? 40 : 0));
      repeat (4) step();
      close_burst();
      drain();
    end

    // R8: overflow when host ignores ready
    pop_en = 0;
    open_burst();
    for (int i = 0; i < DEPTH + 2; i++) send(16'hC000 + 16'(i), 0, 3);
    repeat (2) step();
    check(rx_overflow == 1, "R8 overflow set", rx_overflow, 1);
    close_burst();
    check(rx_overflow == 1, "R8 overflow sticky", rx_overflow, 1);
    drain();
    burst_start = 1; step(); burst_start = 0;
    check(rx_overflow == 0, "R8 cleared by start", rx_overflow, 0);
    host_ack_n = 0; step(); step();
    sent = 0;

    // R9: pop while empty has no effect
    pop_en = 0;
    rx_pop = 1; step(); rx_pop = 0;
    send(16'h5A5A, 1, 4);
    check(rx_valid == 1 && rx_data == 16'h5A5A, "R9 head after empty pop", rx_data, 16'h5A5A);
    close_burst();
    drain();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule